// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an 8-bit up-counter programmed through a small register bus. It works in one of three counting modes: it counts every internal clock cycle, counts selected edges on an external input, or counts internal clock cycles only while the external input sits at a chosen level. The last mode measures pulse widths. When the count passes its top value, the counter reloads from a preload register and keeps counting. The same event sets a sticky request flag, which drives an interrupt output through an enable bit and also sends a wake-up pulse to the power controller.

The external input is asynchronous. It passes through a synchroniser and an edge detector before any mode uses it. Two bus accesses stall counting for the cycle in which they happen: a read of the live count, and a write of the preload value. Software must allow for the count that a stall can lose.

Register map (2-bit address): 0 = control, 1 = preload, 2 = live count (read only), 3 = request flag in bit 0. Control fields: bits [1:0] select the mode (00 idle, 01 internal clock, 10 external edges, 11 gated by external level), bit 3 selects the polarity (0 = rising edge or high level, 1 = falling edge or low level), bit 4 is the run enable, and bit 5 is the interrupt enable. The other control bits read back as 0.

Top module: `tmr_evt_top`

## Requirements
- R1: After reset the control register, preload, count, request flag, `irq_o` and `wake_o` are all 0.
- R2: With mode 01 and bit 4 set, the count goes up by one on every clock. Clearing bit 4 freezes the count.
- R3: With mode 10, the count goes up once for each rising edge (bit 3 = 0) or each falling edge (bit 3 = 1) of `ext_pin`. A change on the pin shows in the count after the third rising clock edge that follows it.
- R4: With mode 11, the count goes up on each clock for which the synchronised pin is high (bit 3 = 0) or low (bit 3 = 1).
- R5: When an increment happens at count 255, the count takes the preload value and the request flag is set.
- R6: `irq_o` is high exactly when the request flag and control bit 5 are both 1.
- R7: After an overflow, `wake_o` pulses high for one cycle if the request flag was 0 before that overflow. The pulse does not depend on bit 5. It does not occur if the flag was already 1.
- R8: A read at address 2 or a write at address 1 blocks that cycle's increment.
- R9: A write at address 1 while bit 4 is 0 loads both the preload and the count. While bit 4 is 1, the same write loads only the preload.
- R10: A write at address 3 sets the flag to the value of data bit 0. An overflow in the same cycle wins and leaves the flag at 1.
- R11: Mode 00 never counts, even with bit 4 set.
- R12: The control, preload and flag registers read back the values written to them, with unused control bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| ext_pin | input | 1 | Asynchronous external count input |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
A wrong count appears at the next read of address 2. The bench reads often, so a count that drifts by even one cycle, for example from a missed stall or a misplaced synchroniser stage, shows up within a few cycles. A bad flag or enable shows on `irq_o` in the very next cycle. A wrong wake-up decision shows on `wake_o` one cycle after the overflow, and the bench compares both outputs on every cycle.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_CLOCK = 2'b01,
    MODE_EDGE  = 2'b10,
    MODE_GATED = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PRE  = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  localparam int B_POL = 3;
  localparam int B_RUN = 4;
  localparam int B_IEN = 5;
  localparam logic [7:0] CTRL_MASK = 8'h3B;

  // Chooses whether this cycle is a counting opportunity.
  function automatic logic f_tick(input tmr_mode_e mode, input logic pol,
                                  input logic rise, input logic fall,
                                  input logic lvl);
    case (mode)
      MODE_CLOCK: f_tick = 1'b1;
      MODE_EDGE:  f_tick = pol ? fall : rise;
      MODE_GATED: f_tick = lvl ^ pol;
      default:    f_tick = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_rise,
  output logic pin_fall
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= pin_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];

  assign pin_lvl  = chain[LAST];
  assign pin_rise = chain[LAST] & ~prev_q;
  assign pin_fall = ~chain[LAST] & prev_q;

  // R3: a detected edge lasts a single cycle
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise);
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |=> !pin_fall);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         inhibit,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] pre_val,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         inc
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] f_next(input logic [W-1:0] c,
                                          input logic [W-1:0] p);
    f_next = (c == TOP) ? p : c + 1'b1;
  endfunction

  assign inc = run & tick & ~inhibit;
  assign ovf = inc & (count == TOP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       count <= '0;
    else if (load_en) count <= load_val;
    else if (inc)     count <= f_next(count, pre_val);

  // R8: a stalled cycle leaves the count untouched
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !load_en) |=> $stable(count));
  // R2: a stopped counter does not move unless loaded
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_en) |=> $stable(count));
endmodule

// File: rtl/tmr_evt_top.sv
module tmr_evt_top
  import tmr_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_pin,
  output logic             irq_o,
  output logic             wake_o
);
  logic [CNT_W-1:0] ctrl_q, pre_q, count;
  logic             flag_q, wake_q;
  logic             lvl, rise, fall, tick, ovf, inc;
  logic             rd_cnt, wr_pre, wr_ctrl, wr_flag, inhibit, run, load_en;
  tmr_mode_e        mode;

  assign rd_cnt  = bus_sel & ~bus_wr & (bus_addr == A_CNT);
  assign wr_pre  = bus_sel &  bus_wr & (bus_addr == A_PRE);
  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign wr_flag = bus_sel &  bus_wr & (bus_addr == A_FLAG);
  assign inhibit = rd_cnt | wr_pre;
  assign run     = ctrl_q[B_RUN];
  assign load_en = wr_pre & ~run;
  assign mode    = tmr_mode_e'(ctrl_q[1:0]);

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pin),
    .pin_lvl(lvl), .pin_rise(rise), .pin_fall(fall));

  assign tick = f_tick(mode, ctrl_q[B_POL], rise, fall, lvl);

  tmr_count_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .inhibit(inhibit),
    .load_en(load_en), .load_val(bus_wdata), .pre_val(pre_q),
    .count(count), .ovf(ovf), .inc(inc));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_pre)  pre_q  <= bus_wdata;
      if (ovf)          flag_q <= 1'b1;
      else if (wr_flag) flag_q <= bus_wdata[0];
      wake_q <= ovf & ~flag_q;
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_PRE:   bus_rdata = pre_q;
      A_CNT:   bus_rdata = count;
      default: bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
    endcase

  assign irq_o  = flag_q & ctrl_q[B_IEN];
  assign wake_o = wake_q;

  // R5: an overflow always leaves the flag set
  p_flag_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);
  // R7: wake is a single-cycle pulse
  p_wake_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  // R7: wake only follows an overflow seen with a clear flag
  p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_o) |-> ($past(ovf) && !$past(flag_q)));
  // R11: the idle mode never increments
  p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |-> !inc);
endmodule

// File: tb/tmr_evt_top_bench.sv
module tmr_evt_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_pin = 1'b0;
  logic       irq_o, wake_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_evt_top u_tmr_evt_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_pin(ext_pin), .irq_o(irq_o), .wake_o(wake_o));

  // reference state
  logic [7:0] m_ctrl, m_pre, m_cnt;
  logic       m_flag, m_wake, m_s1, m_s2, m_s3;

  function automatic logic m_counts(input logic [7:0] c, input logic a,
                                    input logic b);
    // a = current synced level, b = previous synced level
    logic pol;
    pol = c[3];
    if (!c[4]) return 1'b0;
    case (c[1:0])
      2'b01:   return 1'b1;
      2'b10:   return pol ? (!a && b) : (a && !b);
      2'b11:   return pol ? !a : a;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_pre;
      2'd2: return m_cnt;
      default: return {7'd0, m_flag};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cnt = 0; m_flag = 0; m_wake = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic stall, step, wrap, ld;
      stall = bus_sel && ((!bus_wr && bus_addr == 2'd2) || (bus_wr && bus_addr == 2'd1));
      step  = m_counts(m_ctrl, m_s2, m_s3) && !stall;
      wrap  = step && (m_cnt == 8'hFF);
      ld    = bus_sel && bus_wr && bus_addr == 2'd1 && !m_ctrl[4];
      m_wake = wrap && !m_flag;
      if (ld) m_cnt = bus_wdata;
      else if (step) m_cnt = wrap ? m_pre : m_cnt + 8'd1;
      if (bus_sel && bus_wr && bus_addr == 2'd1) m_pre = bus_wdata;
      if (wrap) m_flag = 1'b1;
      else if (bus_sel && bus_wr && bus_addr == 2'd3) m_flag = bus_wdata[0];
      if (bus_sel && bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 8'h3B;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive at negedge, check outputs and read data
  task automatic cyc(input string tag, input logic s, input logic w,
                     input logic [1:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; ext_pin = p;
    #1;
    chk("R6 irq_o", {7'd0, irq_o}, {7'd0, m_flag & m_ctrl[5]});
    chk("R7 wake_o", {7'd0, wake_o}, {7'd0, m_wake});
    if (s && !w) chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic idle(input int n, input logic p);
    for (int i = 0; i < n; i++) cyc("idle", 0, 0, 2'd0, 8'd0, p);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    cyc("R1 ctrl", 1, 0, 2'd0, 0, 0);
    cyc("R1 preload", 1, 0, 2'd1, 0, 0);
    cyc("R1 count", 1, 0, 2'd2, 0, 0);
    cyc("R1 flag", 1, 0, 2'd3, 0, 0);
    // R9 load while stopped; R12 readback
    cyc("w", 1, 1, 2'd1, 8'hF0, 0);
    cyc("R9 count loaded", 1, 0, 2'd2, 0, 0);
    cyc("w", 1, 1, 2'd0, 8'hFF, 0);
    cyc("R12 ctrl mask", 1, 0, 2'd0, 0, 0);
    // R11 idle mode with run
    cyc("w", 1, 1, 2'd0, 8'h10, 0);
    idle(5, 0);
    cyc("R11 no count", 1, 0, 2'd2, 0, 0);
    // R2 clock mode
    cyc("w", 1, 1, 2'd0, 8'h11, 0);
    idle(4, 0);
    cyc("R2 counting", 1, 0, 2'd2, 0, 0);
    // R8 back-to-back reads stall
    cyc("R8 stall", 1, 0, 2'd2, 0, 0);
    cyc("R8 stall", 1, 0, 2'd2, 0, 0);
    // R9 preload write while running does not load
    cyc("w", 1, 1, 2'd1, 8'h20, 0);
    cyc("R9 running", 1, 0, 2'd2, 0, 0);
    // R5/R6 overflow with irq enabled
    cyc("w", 1, 1, 2'd0, 8'h31, 0);
    idle(20, 0);
    cyc("R5 flag", 1, 0, 2'd3, 0, 0);
    cyc("R5 reload", 1, 0, 2'd2, 0, 0);
    // R10 clear
    cyc("w", 1, 1, 2'd3, 8'h00, 0);
    cyc("R10 cleared", 1, 0, 2'd3, 0, 0);
    // R7 flag preset, then overflow: no wake
    cyc("w", 1, 1, 2'd0, 8'h01, 0);
    cyc("w", 1, 1, 2'd1, 8'hFC, 0);
    cyc("w", 1, 1, 2'd3, 8'h01, 0);
    cyc("w", 1, 1, 2'd0, 8'h11, 0);
    idle(6, 0);
    cyc("R7 flag kept", 1, 0, 2'd3, 0, 0);
    // R10 write-zero collides with overflow: overflow wins
    cyc("w", 1, 1, 2'd0, 8'h01, 0);
    cyc("w", 1, 1, 2'd1, 8'hFE, 0);
    cyc("w", 1, 1, 2'd3, 8'h00, 0);
    cyc("w", 1, 1, 2'd0, 8'h11, 0);
    cyc("idle", 0, 0, 2'd0, 0, 0);
    cyc("w", 1, 1, 2'd3, 8'h00, 0);
    cyc("R10 ovf wins", 1, 0, 2'd3, 0, 0);
    // R3 event mode, both polarities
    cyc("w", 1, 1, 2'd0, 8'h01, 0);
    cyc("w", 1, 1, 2'd1, 8'h00, 0);
    cyc("w", 1, 1, 2'd0, 8'h12, 0);
    for (int k = 0; k < 6; k++) begin idle(3, 1); idle(3, 0); end
    cyc("R3 rising", 1, 0, 2'd2, 0, 0);
    cyc("w", 1, 1, 2'd0, 8'h1A, 0);
    for (int k = 0; k < 5; k++) begin idle(2, 1); idle(4, 0); end
    cyc("R3 falling", 1, 0, 2'd2, 0, 0);
    // R4 gated mode, both levels
    cyc("w", 1, 1, 2'd0, 8'h13, 1);
    idle(7, 1);
    cyc("R4 high", 1, 0, 2'd2, 0, 0);
    cyc("w", 1, 1, 2'd0, 8'h1B, 0);
    idle(9, 0);
    cyc("R4 low", 1, 0, 2'd2, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [7:0] d;
      logic p;
      string t;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      p = (($urandom_range(0, 3)) == 0) ? ~ext_pin : ext_pin;
      case (m_ctrl[1:0])
        2'b00: t = "R11 rand";
        2'b01: t = "R2 rand";
        2'b10: t = "R3 rand";
        default: t = "R4 rand";
      endcase
      if (r < 50)      cyc("idle", 0, 0, 2'd0, 0, p);
      else if (r < 70) cyc(t, 1, 0, 2'($urandom), 0, p);
      else if (r < 78) cyc("w", 1, 1, 2'd0, d | 8'h10, p);
      else if (r < 88) cyc("w", 1, 1, 2'd1, d | 8'hE0, p);
      else             cyc("w", 1, 1, 2'd3, d, p);
    end
    cyc("R12 final", 1, 0, 2'd1, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule